// File: doc/BRIEF.md
# Three-wire-command serial word memory (64 x 16)

This block models a small serial word memory that a host drives over a four-wire synchronous link: select, serial clock, serial data in and serial data out. A command is a logic-1 start bit followed by a two-bit operation code and a six-bit word address, all shifted MSB first on rising serial-clock edges while select is high. The block can read a word, program a word, clear a word to all ones, or run the extended commands that touch the whole array or the programming guard.

The serial pins are synchronised into the system clock domain, and rising serial-clock edges are detected there. Storage is an ordinary one-write, one-read word array with no reset, so it can map onto block RAM. A programming sequencer does the power-up fill to all ones and the whole-array operations one word per system clock. It also stands in for the programming delay with a short busy count. A command whose start bit arrives while the sequencer is busy is dropped.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every word reads 16'hFFFF once the power-up fill has finished, the programming guard is closed, and `dout` is 0.
- R2: Zeros clocked in before the first 1 with select high are ignored; that first 1 is the start bit.
- R3: Operation code 2'b10 reads. After the last address bit `dout` shows one 0 bit. Each of the next 16 rising serial edges launches one bit of the word, bit 15 first. The rising edge after those returns `dout` to 0.
- R4: Operation code 2'b01 programs the addressed word with the 16 data bits that follow, bit 15 first, when the guard is open.
- R5: While the guard is closed, single-word programming, single-word clearing, whole-array clearing and whole-array programming change no word.
- R6: Operation code 2'b11 sets the addressed word to 16'hFFFF when the guard is open.
- R7: Operation code 2'b00 with address bits [5:4] = 2'b10 sets every word to 16'hFFFF when the guard is open.
- R8: Operation code 2'b00 with address bits [5:4] = 2'b01 writes the 16 data bits that follow into every word when the guard is open.
- R9: Operation code 2'b00 with address bits [5:4] = 2'b11 opens the guard; with 2'b00 it closes it. Address bits [3:0] are don't-care.
- R10: Dropping select at any point abandons a partly received command, and `dout` is 0 while select is low.
- R11: A single-word program or clear keeps the block busy for BUSY_CYCLES system clocks, and a whole-array operation for 64. A command whose start bit arrives while busy is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Serial select, active high |
| sk | input | 1 | Serial clock; data is taken on its rising edge |
| di | input | 1 | Serial command, address and data input |
| dout | output | 1 | Registered serial read data output |

## Verification
The hardest case to reach from the pins is a command that lands while a program operation is still running. It must be thrown away whole, even though the busy window closes halfway through its header. The stimulus finishes a single-word program, drops and raises select within a few system clocks, and shifts a second program command at once. It then reads both words back after the busy window. A second hard case is a command cut short by select falling in the middle of its data field. The bench then reads the target word back to show that nothing was written.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_RD,
    ST_DONE
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_CLEAR = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_CLRALL = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_in_sync.sv
module mw_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise
);
  logic [STAGES-1:0] cs_p, sk_p, di_p;
  logic              sk_last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_p <= '0;
          sk_p <= '0;
          di_p <= '0;
        end else begin
          cs_p <= cs;
          sk_p <= sk;
          di_p <= di;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_p <= '0;
          sk_p <= '0;
          di_p <= '0;
        end else begin
          cs_p <= {cs_p[STAGES-2:0], cs};
          sk_p <= {sk_p[STAGES-2:0], sk};
          di_p <= {di_p[STAGES-2:0], di};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sk_last <= 1'b0;
    else     sk_last <= sk_p[STAGES-1];
  end

  assign cs_s    = cs_p[STAGES-1];
  assign di_s    = di_p[STAGES-1];
  assign sk_rise = sk_p[STAGES-1] & ~sk_last;
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mw_prog_engine.sv
module mw_prog_engine #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int BUSY_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_all,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          busy,
  output logic          sweeping,
  output logic          init_fill,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  localparam int HW = $clog2(BUSY_CYCLES + 1);

  logic [AW-1:0] idx;
  logic [DW-1:0] fill_q;
  logic [HW-1:0] hold;
  logic          take_one;

  assign busy     = sweeping | (hold != '0);
  assign take_one = go & ~go_all & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweeping  <= 1'b1;
      init_fill <= 1'b1;
      idx       <= '0;
      fill_q    <= '1;
      hold      <= '0;
    end else if (sweeping) begin
      idx <= idx + 1'b1;
      if (&idx) begin
        sweeping  <= 1'b0;
        init_fill <= 1'b0;
      end
    end else if (hold != '0) begin
      hold <= hold - 1'b1;
    end else if (go) begin
      if (go_all) begin
        sweeping <= 1'b1;
        idx      <= '0;
        fill_q   <= go_data;
      end else begin
        hold <= HW'(BUSY_CYCLES);
      end
    end
  end

  always_comb begin
    mem_we    = sweeping | take_one;
    mem_waddr = sweeping ? idx    : go_addr;
    mem_wdata = sweeping ? fill_q : go_data;
  end
endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
  import mw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          di_s,
  input  logic          sk_rise,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          prog_go,
  output logic          prog_all,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          guard_open,
  output mw_state_e     state,
  output logic          dout
);
  localparam int HB = 2 + AW;
  localparam int CMAX = (HB > DW) ? HB : DW;
  localparam int CW = $clog2(CMAX + 1);

  logic [HB-1:0] hdr;
  logic [HB-1:0] hdr_next;
  logic [DW-1:0] dsr, dsr_next, osr;
  logic [CW-1:0] cnt;
  logic          load_pend;
  logic [1:0]    opc, ext;
  logic [AW-1:0] addr;

  assign hdr_next = {hdr[HB-2:0], di_s};
  assign dsr_next = {dsr[DW-2:0], di_s};
  assign opc      = hdr_next[HB-1 -: 2];
  assign ext      = hdr_next[AW-1 -: 2];
  assign addr     = hdr_next[AW-1:0];
  assign rd_addr  = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      hdr        <= '0;
      dsr        <= '0;
      osr        <= '0;
      load_pend  <= 1'b0;
      dout       <= 1'b0;
      guard_open <= 1'b0;
      prog_go    <= 1'b0;
      prog_all   <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
    end else begin
      prog_go   <= 1'b0;
      load_pend <= 1'b0;
      if (load_pend) osr <= rd_data;

      if (!cs_s) begin
        state <= ST_IDLE;
        dout  <= 1'b0;
        cnt   <= '0;
      end else if (sk_rise) begin
        case (state)
          ST_IDLE: begin
            if (busy)      state <= ST_DONE;
            else if (di_s) begin
              state <= ST_HDR;
              cnt   <= '0;
            end
          end
          ST_HDR: begin
            hdr <= hdr_next;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HB - 1)) begin
              cnt <= '0;
              case (opc)
                OP_READ: begin
                  state     <= ST_RD;
                  dout      <= 1'b0;
                  load_pend <= 1'b1;
                end
                OP_WRITE: begin
                  state     <= ST_DATA;
                  prog_all  <= 1'b0;
                  prog_addr <= addr;
                end
                OP_CLEAR: begin
                  state     <= ST_DONE;
                  prog_go   <= guard_open;
                  prog_all  <= 1'b0;
                  prog_addr <= addr;
                  prog_data <= '1;
                end
                default: begin
                  state <= ST_DONE;
                  case (ext)
                    EXT_UNLOCK: guard_open <= 1'b1;
                    EXT_LOCK:   guard_open <= 1'b0;
                    EXT_CLRALL: begin
                      prog_go   <= guard_open;
                      prog_all  <= 1'b1;
                      prog_data <= '1;
                    end
                    default: begin
                      state    <= ST_DATA;
                      prog_all <= 1'b1;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            dsr <= dsr_next;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) begin
              state     <= ST_DONE;
              prog_go   <= guard_open;
              prog_data <= dsr_next;
            end
          end
          ST_RD: begin
            if (cnt == CW'(DW)) begin
              dout  <= 1'b0;
              state <= ST_DONE;
            end else begin
              dout <= osr[DW-1];
              osr  <= {osr[DW-2:0], 1'b0};
              cnt  <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  logic              cs_s, di_s, sk_rise;
  logic              busy, sweeping, init_fill;
  logic              prog_go, prog_all, guard_open;
  logic [ADDR_W-1:0] prog_addr, rd_addr, mem_waddr;
  logic [DATA_W-1:0] prog_data, rd_data, mem_wdata;
  logic              mem_we;
  mw_pkg::mw_state_e fsm_state;

  mw_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise)
  );

  mw_cmd_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise),
    .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr),
    .prog_go(prog_go), .prog_all(prog_all), .prog_addr(prog_addr),
    .prog_data(prog_data), .guard_open(guard_open), .state(fsm_state),
    .dout(dout)
  );

  mw_prog_engine #(.AW(ADDR_W), .DW(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .go(prog_go), .go_all(prog_all),
    .go_addr(prog_addr), .go_data(prog_data), .busy(busy),
    .sweeping(sweeping), .init_fill(init_fill), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  mw_word_array #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      cs_s,
  input logic      dout,
  input mw_state_e state,
  input logic      busy,
  input logic      sweeping,
  input logic      init_fill,
  input logic      mem_we,
  input logic      guard_open
);
  // R10: output is quiet whenever select is low
  a_r10_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !dout);

  // R5: no programming write reaches the array unless the guard is open
  a_r5_write_needs_guard: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !init_fill) |-> guard_open);

  // R11: no new command header is accepted while busy
  a_r11_no_start_while_busy: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && busy) |=> state != ST_HDR);

  // R3: a 1 on the output only comes from the read shifter
  a_r3_one_only_from_read: assert property (@(posedge clk) disable iff (rst)
    $rose(dout) |-> $past(state) == ST_RD);

  // R11: a single-word write leaves the block busy
  a_r11_single_write_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !sweeping) |=> busy);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .dout(dout), .state(fsm_state),
  .busy(busy), .sweeping(sweeping), .init_fill(init_fill),
  .mem_we(mem_we), .guard_open(guard_open)
);

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event smp;

  always #2.5 clk = ~clk;

  mw_eeprom i_mw_eeprom (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .dout(dout)
  );

  // monitor: pops one expected item per sample event
  initial begin
    forever begin
      @(smp);
      if (exp_q.size() != 0) begin
        exp_t it;
        it = exp_q.pop_front();
        n_checks++;
        if (dout !== it.exp) begin
          n_fail++;
          $display("FAIL %s: dout=%b expected %b at %0t", it.tag, dout, it.exp, $time);
        end
      end
    end
  end

  task automatic expect_bit(input logic e, input string tag);
    exp_t it;
    it.exp = e;
    it.tag = tag;
    exp_q.push_back(it);
    ->smp;
    @(negedge clk);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    di = b;
    sk = 1'b0;
    wait_clk(HALF);
    sk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic cs_up();
    sk = 1'b0;
    cs = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic cs_down();
    sk = 1'b0;
    di = 1'b0;
    cs = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic read_word(input logic [5:0] a, input logic [15:0] w, input string tag);
    cs_up();
    send({1'b1, 2'b10}, 3);
    send(a, 6);
    expect_bit(1'b0, {tag, " dummy zero"});
    for (int b = 15; b >= 0; b--) begin
      sk_bit(1'b0);
      expect_bit(w[b], tag);
    end
    sk_bit(1'b0);
    expect_bit(1'b0, {tag, " R3 after last bit"});
    cs_down();
    expect_bit(1'b0, "R10 deselected quiet");
  endtask

  task automatic write_word(input logic [5:0] a, input logic [15:0] w, input int lead);
    cs_up();
    if (lead > 0) send(0, lead);
    send({1'b1, 2'b01}, 3);
    send(a, 6);
    send(w, 16);
    cs_down();
  endtask

  task automatic clear_word(input logic [5:0] a);
    cs_up();
    send({1'b1, 2'b11}, 3);
    send(a, 6);
    cs_down();
  endtask

  task automatic ext_cmd(input logic [1:0] sel, input logic [15:0] w, input bit with_data);
    cs_up();
    send({1'b1, 2'b00}, 3);
    send({sel, 4'b1010}, 6);
    if (with_data) send(w, 16);
    cs_down();
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(10);
    expect_bit(1'b0, "R1 dout low in reset");
    rst = 1'b0;
    wait_clk(100);
    expect_bit(1'b0, "R1 dout low after reset");

    // R1 / R3: fill value after reset
    read_word(6'd5, 16'hFFFF, "R1 R3 power-up word 5");

    // R5: guard closed from reset
    write_word(6'd5, 16'hA5C3, 0);
    wait_clk(100);
    read_word(6'd5, 16'hFFFF, "R5 write while guard closed");

    // R9 open guard; R2 leading zeros; R4 write
    ext_cmd(2'b11, 16'h0, 0);
    write_word(6'd5, 16'hA5C3, 3);
    wait_clk(100);
    read_word(6'd5, 16'hA5C3, "R2 R4 write with leading zeros");
    write_word(6'd6, 16'h1234, 0);
    wait_clk(100);
    read_word(6'd6, 16'h1234, "R4 second word");

    // R6 clear one word
    clear_word(6'd5);
    wait_clk(100);
    read_word(6'd5, 16'hFFFF, "R6 cleared word");
    read_word(6'd6, 16'h1234, "R6 neighbour untouched");

    // R11 command during busy window is dropped
    write_word(6'd7, 16'h0F0F, 0);
    write_word(6'd8, 16'hBEEF, 0);
    wait_clk(100);
    read_word(6'd7, 16'h0F0F, "R11 first write kept");
    read_word(6'd8, 16'hFFFF, "R11 write during busy dropped");

    // R10 abort mid data
    cs_up();
    send({1'b1, 2'b01}, 3);
    send(6'd9, 6);
    send(8'h55, 8);
    cs_down();
    expect_bit(1'b0, "R10 low after abort");
    wait_clk(100);
    read_word(6'd9, 16'hFFFF, "R10 aborted write");

    // R8 write all
    ext_cmd(2'b01, 16'h5A5A, 1);
    wait_clk(100);
    read_word(6'd0, 16'h5A5A, "R8 word 0");
    read_word(6'd63, 16'h5A5A, "R8 word 63");

    // R7 clear all
    ext_cmd(2'b10, 16'h0, 0);
    wait_clk(100);
    read_word(6'd0, 16'hFFFF, "R7 word 0");
    read_word(6'd40, 16'hFFFF, "R7 word 40");

    // R9 close guard; R5 all programming ignored
    ext_cmd(2'b01, 16'h3C3C, 1);
    wait_clk(100);
    ext_cmd(2'b00, 16'h0, 0);
    ext_cmd(2'b10, 16'h0, 0);
    wait_clk(100);
    read_word(6'd10, 16'h3C3C, "R9 R5 clear-all after lock");
    write_word(6'd3, 16'h1111, 0);
    clear_word(6'd4);
    wait_clk(100);
    read_word(6'd3, 16'h3C3C, "R9 R5 write after lock");
    read_word(6'd4, 16'h3C3C, "R9 R5 clear after lock");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule